// File: doc/BRIEF.md
# Decoder-Addressed Configuration Bank Writer

This block turns a stream of packed configuration records into write strobes for a configuration memory array that is split into one or more regions. Every record names a column (bit-line) address, a row (word-line) address and carries one data bit for each region. On acceptance the block decodes both addresses. For each region it drives that region's data bit onto the addressed bit-line. It then raises the addressed word-line for a programmable number of cycles, so that exactly one crossing per region is programmed.

Records arrive on a valid/ready port. Ready stays low for the whole of a write pulse, so the upstream source simply waits. A record whose address falls outside the array is consumed without touching the array, and it sets a sticky error flag. A record-count input gives the length of the stream, and a one-cycle done pulse marks the end of the final record.

Top module: `cfg_bank_writer`

## Requirements
- R1: The record packs the bit-line address in bits [BL_AW-1:0] and the word-line address in bits [BL_AW+WL_AW-1:BL_AW]. The data bit for region r sits at bit BL_AW+WL_AW+r, so region 0 is the lowest data bit.
- R2: After reset, rec_ready is 1 and bl_data, wl_en, cfg_err and stream_done are all 0.
- R3: From the cycle after a valid record is accepted, bit r*NUM_BL+addr of bl_data equals the region-r data bit for every region. All other bl_data bits stay 0.
- R4: In every region, wl_en bit r*NUM_WL+addr is high for exactly P consecutive cycles and no other bit of that region is high. P is the pulse_len value latched at acceptance, and a value of 0 counts as 1.
- R5: The word-line rises one cycle after the bit-lines are first driven. The bit-lines stay driven for one more cycle after the word-line falls, and are 0 the cycle after that.
- R6: rec_ready is 0 from the cycle after a valid record is accepted until the write finishes. It returns to 1 in the cycle in which the bit-lines are released.
- R7: A record with a bit-line address of NUM_BL or more, or a word-line address of NUM_WL or more, is accepted but causes no bl_data or wl_en activity. It sets cfg_err in the cycle after acceptance, and cfg_err stays 1 until reset.
- R8: stream_done pulses for one cycle when record number rec_count of the stream completes. For a valid record this is the cycle in which rec_ready returns. For an out-of-range record it is the cycle after acceptance. The next record then starts a new stream, and out-of-range records count toward rec_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_valid | input | 1 | Record present |
| rec_ready | output | 1 | Block can take a record |
| rec_data | input | BL_AW+WL_AW+REGIONS | Packed record |
| pulse_len | input | PW | Word-line high time in cycles (0 means 1) |
| rec_count | input | CW | Number of records in a stream |
| bl_data | output | REGIONS*NUM_BL | Decoded bit-line data, region-major |
| wl_en | output | REGIONS*NUM_WL | Decoded word-line enables, region-major |
| stream_done | output | 1 | One-cycle end-of-stream pulse |
| cfg_err | output | 1 | Sticky out-of-range address flag |

## Verification
Take E0 as the accepting clock edge of a valid record. The bit-lines and the drop of ready are due after E0. The word-line is due after E0+1 and stays up through E0+P. It is low after E0+P+1 while the bit-lines are still held. The bit-lines are released and ready and done are due after E0+P+2. For an out-of-range record, the error flag and any done pulse are due right after E0. Each scenario task drives inputs on falling edges, steps one falling edge at a time, and compares the outputs against these cycle numbers. A behavioural array model captures rows on word-line edges and is read back once each write is complete.

// File: rtl/cfg_bank_writer.sv
module cfg_bank_writer #(
  parameter int BL_AW   = 5,
  parameter int WL_AW   = 5,
  parameter int REGIONS = 1,
  parameter int NUM_BL  = 32,
  parameter int NUM_WL  = 32,
  parameter int PW      = 8,
  parameter int CW      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rec_valid,
  output logic                          rec_ready,
  input  logic [BL_AW+WL_AW+REGIONS-1:0] rec_data,
  input  logic [PW-1:0]                 pulse_len,
  input  logic [CW-1:0]                 rec_count,
  output logic [REGIONS*NUM_BL-1:0]     bl_data,
  output logic [REGIONS*NUM_WL-1:0]     wl_en,
  output logic                          stream_done,
  output logic                          cfg_err
);
  localparam logic [BL_AW:0] BL_LIM = NUM_BL[BL_AW:0];
  localparam logic [WL_AW:0] WL_LIM = NUM_WL[WL_AW:0];

  typedef enum logic [1:0] {IDLE, SETUP, PULSE, HOLD} st_t;
  st_t st;

  logic [BL_AW-1:0]   bl_a;
  logic [WL_AW-1:0]   wl_a;
  logic [REGIONS-1:0] dat;
  logic [PW-1:0]      left;
  logic [CW-1:0]      seen;
  logic               last_q;

  wire [BL_AW-1:0]   in_bl   = rec_data[BL_AW-1:0];
  wire [WL_AW-1:0]   in_wl   = rec_data[BL_AW+WL_AW-1:BL_AW];
  wire [REGIONS-1:0] in_dat  = rec_data[BL_AW+WL_AW+REGIONS-1:BL_AW+WL_AW];
  wire               in_bad  = ({1'b0, in_bl} >= BL_LIM) || ({1'b0, in_wl} >= WL_LIM);
  wire               in_last = (seen + 1'b1) == rec_count;
  wire               take    = rec_valid && rec_ready;
  wire               bl_drv  = st != IDLE;
  wire               wl_any  = |wl_en;

  assign rec_ready = st == IDLE;

  always_comb begin
    bl_data = '0;
    wl_en   = '0;
    for (int r = 0; r < REGIONS; r++) begin
      if (bl_drv) bl_data[r*NUM_BL + int'(bl_a)] = dat[r];
      if (st == PULSE) wl_en[r*NUM_WL + int'(wl_a)] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= IDLE;
      bl_a        <= '0;
      wl_a        <= '0;
      dat         <= '0;
      left        <= '0;
      seen        <= '0;
      last_q      <= 1'b0;
      stream_done <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      stream_done <= 1'b0;
      case (st)
        IDLE: if (take) begin
          seen <= in_last ? '0 : seen + 1'b1;
          if (in_bad) begin
            cfg_err     <= 1'b1;
            stream_done <= in_last;
          end else begin
            bl_a   <= in_bl;
            wl_a   <= in_wl;
            dat    <= in_dat;
            left   <= (pulse_len == '0) ? {{(PW-1){1'b0}}, 1'b1} : pulse_len;
            last_q <= in_last;
            st     <= SETUP;
          end
        end
        SETUP: st <= PULSE;
        PULSE: if (left == {{(PW-1){1'b0}}, 1'b1}) st <= HOLD;
               else left <= left - 1'b1;
        HOLD: begin
          st          <= IDLE;
          stream_done <= last_q;
        end
        default: st <= IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < REGIONS; r++) begin : g_chk
    assert_wl_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wl_en[r*NUM_WL +: NUM_WL]));
  end

  assert_bl_before_wl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wl_any) |-> ($past(bl_drv) && bl_drv));
  assert_bl_after_wl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wl_any) |-> bl_drv);
  assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wl_any |-> !rec_ready);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stream_done |=> !stream_done);
endmodule

// File: tb/tb_cfg_bank_writer.sv
module tb_cfg_bank_writer;
  localparam int BA = 5, WA = 5, RG = 2, NB = 24, NW = 20, PW = 8, CW = 16;

  logic clk = 0, rst_n = 0, rec_valid = 0;
  logic rec_ready, stream_done, cfg_err;
  logic [BA+WA+RG-1:0] rec_data = '0;
  logic [PW-1:0] pulse_len = '0;
  logic [CW-1:0] rec_count = '0;
  logic [RG*NB-1:0] bl_data;
  logic [RG*NW-1:0] wl_en;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [NB-1:0] mem [RG][NW];

  always #10 clk = ~clk;

  cfg_bank_writer #(.BL_AW(BA), .WL_AW(WA), .REGIONS(RG), .NUM_BL(NB),
                    .NUM_WL(NW), .PW(PW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_data(rec_data), .pulse_len(pulse_len), .rec_count(rec_count),
    .bl_data(bl_data), .wl_en(wl_en), .stream_done(stream_done), .cfg_err(cfg_err));

  always @(posedge clk)
    for (int r = 0; r < RG; r++)
      for (int w = 0; w < NW; w++)
        if (wl_en[r*NW+w]) mem[r][w] <= bl_data[r*NB +: NB];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: act %0d cycles exp completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act %0h exp %0h", req, what, act, exp);
    end
  endtask

  // R1 packing: {data, wl, bl}; region r data at bit BA+WA+r
  task automatic do_rec(input int b, input int w, input logic [RG-1:0] d,
                        input int p, input bit last, input bit bad);
    logic [RG*NB-1:0] ebl = '0;
    logic [RG*NW-1:0] ewl = '0;
    int pe = (p == 0) ? 1 : p;
    for (int r = 0; r < RG; r++) begin
      if (d[r]) ebl[r*NB+b] = 1'b1;
      ewl[r*NW+w] = 1'b1;
    end
    @(negedge clk);
    chk(rec_ready == 1, "R6", "ready before record", rec_ready, 1);
    rec_valid = 1; rec_data = {d, w[WA-1:0], b[BA-1:0]}; pulse_len = p[PW-1:0];
    @(negedge clk);
    rec_valid = 0;
    if (bad) begin
      chk(bl_data == 0 && wl_en == 0, "R7", "no strobes on bad addr", {16'd0, bl_data}, 0);
      chk(cfg_err == 1, "R7", "err set", cfg_err, 1);
      chk(stream_done == last, "R8", "done after bad record", stream_done, last);
      chk(rec_ready == 1, "R7", "ready after bad record", rec_ready, 1);
      @(negedge clk);
      chk(bl_data == 0 && wl_en == 0 && !stream_done, "R7", "quiet after bad", {16'd0, bl_data}, 0);
      return;
    end
    chk(bl_data == ebl, "R3", "bl driven in setup", bl_data, ebl);
    chk(wl_en == 0, "R5", "wl low in setup", wl_en, 0);
    chk(rec_ready == 0, "R6", "ready low in setup", rec_ready, 0);
    for (int k = 0; k < pe; k++) begin
      @(negedge clk);
      chk(wl_en == ewl, "R4", "wl pulse", wl_en, ewl);
      chk(bl_data == ebl, "R3", "bl held in pulse", bl_data, ebl);
    end
    @(negedge clk);
    chk(wl_en == 0, "R4", "wl off after P cycles", wl_en, 0);
    chk(bl_data == ebl, "R5", "bl held after wl falls", bl_data, ebl);
    chk(rec_ready == 0, "R6", "ready low in hold", rec_ready, 0);
    chk(stream_done == 0, "R8", "no early done", stream_done, 0);
    @(negedge clk);
    chk(bl_data == 0, "R5", "bl released", bl_data, 0);
    chk(rec_ready == 1, "R6", "ready returns", rec_ready, 1);
    chk(stream_done == last, "R8", "done at write end", stream_done, last);
    for (int r = 0; r < RG; r++)
      chk(mem[r][w] == ebl[r*NB +: NB], "R3", "array row written",
          {40'd0, mem[r][w]}, {40'd0, ebl[r*NB +: NB]});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rec_ready == 1 && bl_data == 0 && wl_en == 0 && !stream_done && !cfg_err,
        "R2", "reset state", {rec_ready, stream_done, cfg_err}, 3'b100);
  endtask

  task automatic t_stream_a;
    rec_count = 4;
    do_rec(3, 7, 2'b01, 3, 0, 0);   // R1 region 0 only
    do_rec(23, 19, 2'b10, 0, 0, 0); // R4 zero length, edge addresses
    do_rec(25, 2, 2'b11, 2, 0, 1);  // R7 bl out of range
    do_rec(0, 0, 2'b11, 1, 1, 0);   // R8 last
    @(negedge clk);
    chk(stream_done == 0, "R8", "done one cycle", stream_done, 0);
    chk(cfg_err == 1, "R7", "err sticky", cfg_err, 1);
  endtask

  task automatic t_stream_b;
    rec_count = 2;
    do_rec(10, 5, 2'b11, 4, 0, 0);
    do_rec(4, 21, 2'b01, 1, 1, 1);  // R7 wl out of range, last record R8
    chk(cfg_err == 1, "R7", "err still set", cfg_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_stream_a();
    t_stream_b();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule